// File: doc/BRIEF.md
# Pin Configuration Register Bank with Masked Broadcast

This block holds the configuration words for 32 pins. Each pin owns one 16-bit field. The bank does not interpret these bits: it stores them and drives them out in parallel to the pin logic on one wide bus. Software can reach each pin field on its own through a word address. Two write-only broadcast words let one bus write load the same 16-bit value into any chosen subset of one half of the pins. The low broadcast word covers pins 0 to 15 and the high one covers pins 16 to 31.

The bus is a simple synchronous request interface. An access is presented for one cycle with `bus_req` high. Writes take effect on that clock edge. In the next cycle `bus_ready` rises and `bus_rdata` holds the result. Every access completes in exactly one cycle.

Top module: `pinctl_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, every pin field, `bus_rdata` and `bus_ready` are zero.
- R2: A write at byte offset 4·n (n = 0..31, the low two address bits zero) loads field n from `bus_wdata[15:0]`; bits 31:16 are discarded. A read there returns field n in bits 15:0, with bits 31:16 zero.
- R3: On a direct pin write, `bus_be[0]` enables bits 7:0 and `bus_be[1]` enables bits 15:8; `bus_be[3:2]` have no effect on it.
- R4: A write at offset 0x80 with `bus_be` = 4'b1111 treats `bus_wdata[31:16]` as a mask. Every pin n (0..15) whose mask bit n is set gets `bus_wdata[15:0]` on the same edge; all other pins keep their values.
- R5: A write at offset 0x84 with `bus_be` = 4'b1111 does the same for pin 16+n under mask bit n, and leaves pins 0..15 unchanged.
- R6: A write to 0x80 or 0x84 with any `bus_be` bit low changes no pin field.
- R7: A read of 0x80 or 0x84 returns zero. A broadcast write whose mask is all zero changes nothing.
- R8: Every other offset (0x88 to 0xFC, and any address whose low two bits are not zero) reads as zero and ignores writes.
- R9: `bus_ready` is high in exactly the cycle after each cycle with `bus_req` high. The `bus_rdata` that goes with a write is zero.
- R10: `pin_cfg[16n+15:16n]` carries field n. It changes only on the edge of an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_be | input | 4 | Byte enables of the write data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access completion |
| pin_cfg | output | 512 | All pin fields, pin 0 in the least significant bits |

## Verification
The checker watches the bus timing on every cycle: ready follows each request, and the upper half of read data stays zero. It also watches what must stay frozen. The pin bus holds when no write occurs, and it holds after partial, zero-mask or unmapped broadcast-region writes. A low-half broadcast leaves the high half alone, and a high-half broadcast leaves the low half alone. These checks prove only that the right things hold still. Only the bench scenarios show that the right fields take the right values. That covers byte-lane merging on direct writes, mask-to-pin mapping in both halves and readback contents, all compared against a model of the register file.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int unsigned PC_NPINS   = 32;
  localparam int unsigned PC_FIELD_W = 16;
  localparam int unsigned PC_DATA_W  = 32;
  localparam int unsigned PC_ADDR_W  = 8;
endpackage

// File: rtl/pinctl_decode.sv
module pinctl_decode #(
  parameter int unsigned NPINS   = pinctl_pkg::PC_NPINS,
  parameter int unsigned FIELD_W = pinctl_pkg::PC_FIELD_W,
  parameter int unsigned DATA_W  = pinctl_pkg::PC_DATA_W,
  parameter int unsigned ADDR_W  = pinctl_pkg::PC_ADDR_W
) (
  input  logic                     req,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W/8-1:0]      be,
  input  logic [DATA_W-1:FIELD_W]  mask_in,
  output logic [NPINS-1:0]         dir_wr,
  output logic [NPINS-1:0]         bc_wr,
  output logic                     rd_hit,
  output logic [$clog2(NPINS)-1:0] rd_idx
);
  localparam int unsigned IDX_W   = $clog2(NPINS);
  localparam int unsigned HALF    = NPINS / 2;
  localparam int unsigned DIR_END = NPINS * 4;

  logic aligned, in_dir, is_lo, is_hi, full;

  assign aligned = (addr[1:0] == 2'b00);
  assign in_dir  = aligned && (addr < ADDR_W'(DIR_END));
  assign is_lo   = (addr == ADDR_W'(DIR_END));
  assign is_hi   = (addr == ADDR_W'(DIR_END + 4));
  assign full    = &be;
  assign rd_hit  = in_dir;
  assign rd_idx  = addr[IDX_W+1:2];

  always_comb begin
    dir_wr = '0;
    bc_wr  = '0;
    if (req && we) begin
      if (in_dir) dir_wr[rd_idx] = 1'b1;
      if (full && is_lo) bc_wr[HALF-1:0]     = mask_in;
      if (full && is_hi) bc_wr[NPINS-1:HALF] = mask_in;
    end
  end
endmodule

// File: rtl/pinctl_cell.sv
module pinctl_cell #(
  parameter int unsigned FIELD_W = pinctl_pkg::PC_FIELD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dir_wr,
  input  logic [FIELD_W/8-1:0]   dir_be,
  input  logic                   bc_wr,
  input  logic [FIELD_W-1:0]     wdata,
  output logic [FIELD_W-1:0]     q
);
  localparam int unsigned NBYTES = FIELD_W / 8;

  logic [FIELD_W-1:0] q_nxt;
  logic               q_en;

  assign q_en = dir_wr | bc_wr;

  always_comb begin
    q_nxt = q;
    if (bc_wr) begin
      q_nxt = wdata;
    end else begin
      for (int b = 0; b < NBYTES; b++) begin
        if (dir_be[b]) q_nxt[b*8 +: 8] = wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank #(
  parameter int unsigned NPINS   = pinctl_pkg::PC_NPINS,
  parameter int unsigned FIELD_W = pinctl_pkg::PC_FIELD_W,
  parameter int unsigned DATA_W  = pinctl_pkg::PC_DATA_W,
  parameter int unsigned ADDR_W  = pinctl_pkg::PC_ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_req,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W/8-1:0]        bus_be,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_ready,
  output logic [NPINS*FIELD_W-1:0]   pin_cfg
);
  localparam int unsigned IDX_W = $clog2(NPINS);

  logic [NPINS-1:0]   dir_wr, bc_wr;
  logic               rd_hit;
  logic [IDX_W-1:0]   rd_idx;
  logic [FIELD_W-1:0] fld [NPINS];
  logic [DATA_W-1:0]  rdata_nxt;
  logic               rdata_en;

  pinctl_decode #(.NPINS(NPINS), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .be(bus_be),
    .mask_in(bus_wdata[DATA_W-1:FIELD_W]),
    .dir_wr(dir_wr), .bc_wr(bc_wr), .rd_hit(rd_hit), .rd_idx(rd_idx)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pinctl_cell #(.FIELD_W(FIELD_W)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .dir_wr(dir_wr[g]), .dir_be(bus_be[FIELD_W/8-1:0]),
      .bc_wr(bc_wr[g]), .wdata(bus_wdata[FIELD_W-1:0]),
      .q(fld[g])
    );
    assign pin_cfg[g*FIELD_W +: FIELD_W] = fld[g];
  end

  assign rdata_en = bus_req;

  always_comb begin
    rdata_nxt = '0;
    if (!bus_we && rd_hit) rdata_nxt = DATA_W'(fld[rd_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_req;
      if (rdata_en) bus_rdata <= rdata_nxt;
    end
  end
endmodule

// File: rtl/pinctl_chk.sv
module pinctl_chk #(
  parameter int unsigned NPINS   = 32,
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_req,
  input logic                     bus_we,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W/8-1:0]      bus_be,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic                     bus_ready,
  input logic [NPINS*FIELD_W-1:0] pin_cfg
);
  localparam int unsigned HALFBITS = NPINS * FIELD_W / 2;
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(NPINS * 4);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(NPINS * 4 + 4);

  logic wr, bc_addr, full, zmask, unmapped;
  assign wr       = bus_req && bus_we;
  assign bc_addr  = (bus_addr == A_LO) || (bus_addr == A_HI);
  assign full     = &bus_be;
  assign zmask    = (bus_wdata[DATA_W-1:FIELD_W] == '0);
  assign unmapped = !bc_addr && !((bus_addr[1:0] == 2'b00) && (bus_addr < A_LO));

  AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ready);                                          // R9
  AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ready);                                        // R9
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> bus_rdata[DATA_W-1:FIELD_W] == '0);               // R2
  AST_BCAST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bc_addr) |=> bus_rdata == '0);           // R7
  AST_PARTIAL_BCAST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bc_addr && !full) |=> $stable(pin_cfg));                 // R6
  AST_ZERO_MASK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bc_addr && zmask) |=> $stable(pin_cfg));                 // R7
  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && unmapped) |=> $stable(pin_cfg));                         // R8
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(pin_cfg));                                      // R10
  AST_LO_BCAST_SPARES_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_LO) |=> $stable(pin_cfg[2*HALFBITS-1:HALFBITS])); // R4
  AST_HI_BCAST_SPARES_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_HI) |=> $stable(pin_cfg[HALFBITS-1:0]));  // R5
endmodule

bind pinctl_bank pinctl_chk #(.NPINS(NPINS), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
  .pin_cfg(pin_cfg)
);

// File: tb/sim_pinctl_bank.sv
module sim_pinctl_bank;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_req, bus_we;
  logic [7:0]   bus_addr;
  logic [3:0]   bus_be;
  logic [31:0]  bus_wdata, bus_rdata;
  logic         bus_ready;
  logic [511:0] pin_cfg;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m [32];
  logic [31:0] expq [$];
  string       tagq [$];

  always #2 clk = ~clk;

  pinctl_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .pin_cfg(pin_cfg)
  );

  function automatic logic [31:0] exp_read(logic [7:0] a);
    if (a[1:0] == 2'b00 && a < 8'h80) return {16'h0, m[a[6:2]]};
    return 32'h0;
  endfunction

  task automatic model_write(logic [7:0] a, logic [3:0] be, logic [31:0] wd);
    if (a[1:0] == 2'b00 && a < 8'h80) begin
      if (be[0]) m[a[6:2]][7:0]  = wd[7:0];
      if (be[1]) m[a[6:2]][15:8] = wd[15:8];
    end else if (be == 4'hF && (a == 8'h80 || a == 8'h84)) begin
      for (int n = 0; n < 16; n++)
        if (wd[16+n]) m[n + (a == 8'h84 ? 16 : 0)] = wd[15:0];
    end
  endtask

  // Driver: presents one access and pushes its expected read data.
  task automatic access(string tag, logic we, logic [7:0] a, logic [3:0] be, logic [31:0] wd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    expq.push_back(we ? 32'h0 : exp_read(a));
    tagq.push_back(tag);
    @(posedge clk);
    #1 bus_req = 1'b0;
    if (we) model_write(a, be, wd);
  endtask

  task automatic check_cfg(string tag);
    int bad_pin = -1;
    @(negedge clk);
    n_chk++;
    for (int n = 0; n < 32; n++)
      if (bad_pin < 0 && pin_cfg[n*16 +: 16] !== m[n]) bad_pin = n;
    if (bad_pin >= 0) begin
      n_bad++;
      $display("FAIL %s pin_cfg pin %0d actual %h expected %h", tag, bad_pin,
               pin_cfg[bad_pin*16 +: 16], m[bad_pin]);
    end
  endtask

  // Monitor: pops one expected item per completed access.
  always @(negedge clk) begin
    if (rst_n && bus_ready) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected ready actual 1 expected 0");
      end else begin
        logic [31:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s rdata actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int n = 0; n < 32; n++) m[n] = 16'h0;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (pin_cfg !== '0 || bus_ready !== 1'b0 || bus_rdata !== '0) begin
      n_bad++;
      $display("FAIL R1 reset state actual cfg_nonzero=%0b ready=%b rdata=%h expected 0",
               pin_cfg != '0, bus_ready, bus_rdata);
    end
    check_cfg("R1");

    // R2 direct full-word writes, upper bits discarded
    access("R2", 1, 8'h00, 4'hF, 32'hDEAD_1234);
    access("R2", 1, 8'h7C, 4'hF, 32'hFFFF_BEEF);
    access("R2", 1, 8'h28, 4'hF, 32'h0001_00C3);
    access("R2", 0, 8'h00, 4'hF, 32'h0);
    access("R2", 0, 8'h7C, 4'hF, 32'h0);
    access("R2", 0, 8'h28, 4'hF, 32'h0);
    check_cfg("R10");

    // R3 byte lanes
    access("R3", 1, 8'h04, 4'b0001, 32'hAAAA_5511);
    access("R3", 1, 8'h04, 4'b0010, 32'hAAAA_7722);
    access("R3", 1, 8'h04, 4'b1100, 32'hFFFF_FFFF);
    access("R3", 0, 8'h04, 4'hF, 32'h0);
    check_cfg("R3");

    // R4 low broadcast, R7 readback zero
    access("R4", 1, 8'h80, 4'hF, 32'h00F5_A55A);
    check_cfg("R4");
    access("R7", 0, 8'h80, 4'hF, 32'h0);
    // R5 high broadcast
    access("R5", 1, 8'h84, 4'hF, 32'h8001_1234);
    check_cfg("R5");
    access("R7", 0, 8'h84, 4'hF, 32'h0);
    access("R5", 0, 8'h40, 4'hF, 32'h0);
    access("R5", 0, 8'h7C, 4'hF, 32'h0);
    // R6 partial broadcast ignored
    access("R6", 1, 8'h80, 4'b0111, 32'hFFFF_0BAD);
    access("R6", 1, 8'h84, 4'b1110, 32'hFFFF_0BAD);
    check_cfg("R6");
    // R7 zero mask
    access("R7", 1, 8'h80, 4'hF, 32'h0000_FFFF);
    access("R7", 1, 8'h84, 4'hF, 32'h0000_FFFF);
    check_cfg("R7");
    // R8 unmapped
    access("R8", 1, 8'h88, 4'hF, 32'hFFFF_FFFF);
    access("R8", 1, 8'h02, 4'hF, 32'h1234_5678);
    access("R8", 1, 8'hFC, 4'hF, 32'hFFFF_FFFF);
    access("R8", 0, 8'h88, 4'hF, 32'h0);
    access("R8", 0, 8'h01, 4'hF, 32'h0);
    check_cfg("R8");
    // R4/R5 full masks
    access("R4", 1, 8'h80, 4'hF, 32'hFFFF_3C3C);
    access("R5", 1, 8'h84, 4'hF, 32'hFFFF_C3C3);
    check_cfg("R4");

    // mixed stream
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      logic [31:0] rnd;
      rnd = $urandom;
      case (rnd[2:0])
        3'd0: a = 8'h80;
        3'd1: a = 8'h84;
        3'd2: a = 8'h88 + 8'(rnd[5:3] * 4);
        default: a = {1'b0, rnd[10:6], 2'b00};
      endcase
      r = $urandom;
      access("R9", rnd[11], a, (rnd[12] ? 4'hF : rnd[16:13]), r);
      if (i % 25 == 0) check_cfg("R10");
    end
    check_cfg("R10");
    @(negedge clk);
    @(negedge clk);
    n_chk++;
    if (expq.size() != 0) begin
      n_bad++;
      $display("FAIL R9 pending accesses actual %0d expected 0", expq.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule